// File: doc/BRIEF.md
# Core Test Wrapper Instruction Controller

This block is the serial control heart of a test wrapper around an embedded core. A test controller drives it with a wrapper clock, an active-low wrapper reset, a select line that picks the instruction register, and shift, capture and update enables. Serial data enters on one input. The block holds an instruction register, made of a shift stage and a separate update stage, a decoder, and a bypass shift register whose length is a parameter. It routes the scan-out of the selected register to a serial output that is retimed on the falling clock edge.

The decoded instruction drives the wrapper's mode outputs: bypass, external test, internal test and preload. It also drives a select for the boundary register, which sits outside this block, and a line that turns the boundary cells toward the core. The boundary register returns its scan-out through a dedicated input. Under the three boundary instructions, the block passes that input to the serial output.

Top module: `ctw_ctrl`

## Requirements
- R1: While `wrst_n` is 0, the active instruction is forced at once, without waiting for a clock edge, to bypass (code 000) and the serial output is 0. The shift stage and the bypass register are cleared to 0 at the same time.
- R2: When `sel_ir` is 1, the instruction shift stage is the register connected to the serial path, whatever instruction is active. On each rising edge with `shift_en`=1, `si` enters the most significant bit and bit 0 leaves toward `so`.
- R3: A rising edge with `sel_ir`=1 and `capture_en`=1 loads the instruction shift stage with the value 001: bit 0 is 1 and every other bit is 0. Capture takes priority over shift.
- R4: The active instruction takes the value of the shift stage on a falling edge that has `sel_ir`=1 and `update_en`=1. In every other case it keeps its value, including an update request while `sel_ir` is 0.
- R5: The instruction is 3 bits wide and decodes as follows: 000 is bypass, 001 is external test, 010 is internal test and 011 is preload. Every other code decodes as bypass. Exactly one of the four mode outputs is 1.
- R6: When `sel_ir` is 0 and the bypass instruction is active, the bypass register of BYP_LEN stages sits between `si` and `so`. A bit shifted in on a rising edge reaches `so` BYP_LEN-1 cycles later, at the falling edge.
- R7: A rising edge with `capture_en`=1 while the bypass register is on the path loads every bypass stage with 0.
- R8: Under external test, internal test or preload, `bnd_select` is 1. With `sel_ir`=0, `so` then carries only `bnd_so`, with nothing in series.
- R9: `cell_inward` is 1 only under internal test.
- R10: `so` changes only on the falling clock edge or on reset. It is sampled from the selected path at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Wrapper clock |
| wrst_n | input | 1 | Asynchronous active-low wrapper reset |
| sel_ir | input | 1 | 1 selects the instruction register for the serial path |
| shift_en | input | 1 | Shift enable for the selected register |
| capture_en | input | 1 | Capture enable for the selected register |
| update_en | input | 1 | Instruction update enable (acts on the falling edge) |
| si | input | 1 | Serial input |
| bnd_so | input | 1 | Scan-out returned from the boundary register |
| so | output | 1 | Retimed serial output |
| mode_bypass | output | 1 | Bypass instruction active |
| mode_extest | output | 1 | External test instruction active |
| mode_intest | output | 1 | Internal test instruction active |
| mode_preload | output | 1 | Preload instruction active |
| bnd_select | output | 1 | Boundary register selected as the data register |
| cell_inward | output | 1 | Boundary cells face the core |

## Verification
The hardest case to reach is a falling-edge update that meets a shift stage which a capture and a partial shift in the same window have just rewritten. The active code then comes from an unused encoding, and the path switches between bypass and boundary at the same edge that retimes the output. A long stream of random operations on a fixed seed steers the block into these collisions, since updates, captures and shifts are often asserted together. Directed sequences first load each defined code and an unused code on purpose, and pulse the reset between clock edges.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
  typedef enum logic [1:0] {
    OP_BYPASS  = 2'd0,
    OP_EXTEST  = 2'd1,
    OP_INTEST  = 2'd2,
    OP_PRELOAD = 2'd3
  } op_e;

  typedef struct packed {
    logic bypass;
    logic extest;
    logic intest;
    logic preload;
    logic bnd_sel;
    logic inward;
  } mode_t;
endpackage

// File: rtl/ctw_ir.sv
module ctw_ir #(
  parameter int IR_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            shift_en,
  input  logic            capture_en,
  input  logic            update_en,
  input  logic            si,
  output logic            scan_out,
  output logic [IR_W-1:0] active
);
  localparam logic [IR_W-1:0] CAPT_VAL = IR_W'(2'b01);
  localparam logic [IR_W-1:0] RST_VAL  = '0;

  logic [IR_W-1:0] shreg;

  // shift stage: rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (sel && capture_en) begin
      shreg <= CAPT_VAL;
    end else if (sel && shift_en) begin
      shreg <= {si, shreg[IR_W-1:1]};
    end
  end

  // update stage: falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= RST_VAL;
    end else if (sel && update_en) begin
      active <= shreg;
    end
  end

  assign scan_out = shreg[0];

  assert_capture_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && capture_en) |=> (shreg == CAPT_VAL));

  assert_hold_no_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || !update_en) |=> $stable(active));
endmodule

// File: rtl/ctw_byp.sv
module ctw_byp #(
  parameter int BYP_LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic shift_en,
  input  logic capture_en,
  input  logic si,
  output logic scan_out
);
  logic [BYP_LEN-1:0] q;

  generate
    if (BYP_LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 q <= '0;
        else if (en && capture_en)  q <= '0;
        else if (en && shift_en)    q <= si;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 q <= '0;
        else if (en && capture_en)  q <= '0;
        else if (en && shift_en)    q <= {si, q[BYP_LEN-1:1]};
      end
    end
  endgenerate

  assign scan_out = q[0];

  assert_byp_shift_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && shift_en && !capture_en) |=> (q[BYP_LEN-1] == $past(si)));

  assert_byp_capture_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && capture_en) |=> (q == '0));
endmodule

// File: rtl/ctw_dec.sv
module ctw_dec
  import ctw_pkg::*;
#(
  parameter int IR_W = 3
) (
  input  logic [IR_W-1:0] active,
  output mode_t           mode
);
  localparam int HI_W = IR_W - 2;

  op_e op;

  always_comb begin
    if (active[IR_W-1:2] == HI_W'(0)) op = op_e'(active[1:0]);
    else                              op = OP_BYPASS;
  end

  always_comb begin
    mode         = '0;
    mode.bypass  = (op == OP_BYPASS);
    mode.extest  = (op == OP_EXTEST);
    mode.intest  = (op == OP_INTEST);
    mode.preload = (op == OP_PRELOAD);
    mode.bnd_sel = (op != OP_BYPASS);
    mode.inward  = (op == OP_INTEST);
  end
endmodule

// File: rtl/ctw_ctrl.sv
module ctw_ctrl
  import ctw_pkg::*;
#(
  parameter int IR_W    = 3,
  parameter int BYP_LEN = 1
) (
  input  logic wclk,
  input  logic wrst_n,
  input  logic sel_ir,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic si,
  input  logic bnd_so,
  output logic so,
  output logic mode_bypass,
  output logic mode_extest,
  output logic mode_intest,
  output logic mode_preload,
  output logic bnd_select,
  output logic cell_inward
);
  logic [IR_W-1:0] active;
  logic            ir_so;
  logic            byp_so;
  logic            byp_en;
  logic            path_bit;
  mode_t           mode;

  ctw_ir #(.IR_W(IR_W)) u_ir (
    .clk(wclk), .rst_n(wrst_n), .sel(sel_ir), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .si(si),
    .scan_out(ir_so), .active(active)
  );

  ctw_dec #(.IR_W(IR_W)) u_dec (.active(active), .mode(mode));

  assign byp_en = !sel_ir && mode.bypass;

  ctw_byp #(.BYP_LEN(BYP_LEN)) u_byp (
    .clk(wclk), .rst_n(wrst_n), .en(byp_en), .shift_en(shift_en),
    .capture_en(capture_en), .si(si), .scan_out(byp_so)
  );

  // instruction path wins, then boundary, bypass by default
  always_comb begin
    if (sel_ir)            path_bit = ir_so;
    else if (mode.bnd_sel) path_bit = bnd_so;
    else                   path_bit = byp_so;
  end

  always_ff @(negedge wclk or negedge wrst_n) begin
    if (!wrst_n) so <= 1'b0;
    else         so <= path_bit;
  end

  assign mode_bypass  = mode.bypass;
  assign mode_extest  = mode.extest;
  assign mode_intest  = mode.intest;
  assign mode_preload = mode.preload;
  assign bnd_select   = mode.bnd_sel;
  assign cell_inward  = mode.inward;

  assert_bnd_path_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
    (!sel_ir && bnd_select) |=> (so == $past(bnd_so)));

  assert_one_mode_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0({mode_bypass, mode_extest, mode_intest, mode_preload})
    && (mode_bypass || mode_extest || mode_intest || mode_preload));
endmodule

// File: tb/ctw_ctrl_test.sv
`timescale 1ns/100ps
module ctw_ctrl_test;
  localparam int W = 3;
  localparam int N = 3;

  logic wclk = 1'b0;
  logic wrst_n = 1'b1;
  logic sel_ir = 0, shift_en = 0, capture_en = 0, update_en = 0, si = 0, bnd_so = 0;
  logic so, mode_bypass, mode_extest, mode_intest, mode_preload, bnd_select, cell_inward;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] m_ir, m_act;
  logic [N-1:0] m_byp;
  logic         m_so;

  always #2.5 wclk = ~wclk;

  ctw_ctrl #(.IR_W(W), .BYP_LEN(N)) uut (
    .wclk(wclk), .wrst_n(wrst_n), .sel_ir(sel_ir), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .si(si), .bnd_so(bnd_so),
    .so(so), .mode_bypass(mode_bypass), .mode_extest(mode_extest),
    .mode_intest(mode_intest), .mode_preload(mode_preload),
    .bnd_select(bnd_select), .cell_inward(cell_inward)
  );

  // {bypass, extest, intest, preload, bnd_select, inward}
  function automatic logic [5:0] exp_modes(input logic [W-1:0] c);
    case (c)
      3'b001:  return 6'b010010;
      3'b010:  return 6'b001011;
      3'b011:  return 6'b000110;
      default: return 6'b100000;
    endcase
  endfunction

  function automatic logic [5:0] got_modes();
    return {mode_bypass, mode_extest, mode_intest, mode_preload, bnd_select, cell_inward};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ir = '0; m_act = '0; m_byp = '0; m_so = 1'b0;
  endtask

  // entered just after a falling edge; leaves just after the next one
  task automatic step(input logic s, input logic sh, input logic cp, input logic up,
                      input logic d, input logic b);
    logic so_before;
    sel_ir = s; shift_en = sh; capture_en = cp; update_en = up; si = d; bnd_so = b;
    so_before = so;
    @(posedge wclk); #0.5;
    chk(so === so_before, "R10", {7'd0, so}, {7'd0, so_before});
    if (s) begin
      if (cp)      m_ir = 3'b001;
      else if (sh) m_ir = {d, m_ir[W-1:1]};
    end else if (exp_modes(m_act)[5]) begin
      if (cp)      m_byp = '0;
      else if (sh) m_byp = {d, m_byp[N-1:1]};
    end
    @(negedge wclk);
    m_so = s ? m_ir[0] : (exp_modes(m_act)[1] ? b : m_byp[0]);
    if (s && up) m_act = m_ir;
    #1;
    chk(so === m_so, s ? "R2" : (exp_modes(m_act)[1] ? "R8" : "R6"),
        {7'd0, so}, {7'd0, m_so});
    chk(got_modes() === exp_modes(m_act), "R5", {2'd0, got_modes()}, {2'd0, exp_modes(m_act)});
  endtask

  task automatic load_instr(input logic [W-1:0] c);
    for (int i = 0; i < W; i++) step(1, 1, 0, 0, c[i], 0);
    step(1, 0, 0, 1, 0, 0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int junk;
    junk = $urandom(32'd4242);
    model_reset();
    #1 wrst_n = 1'b0;
    #0.5;
    // R1 reset state, before any clock edge
    chk(so === 1'b0, "R1", {7'd0, so}, 8'd0);
    chk(got_modes() === 6'b100000, "R1", {2'd0, got_modes()}, 8'h20);
    repeat (3) @(negedge wclk);
    #1 wrst_n = 1'b1;

    // R3 capture shows 1 then 0,0 at the instruction path
    step(1, 0, 1, 0, 0, 0);
    chk(so === 1'b1, "R3", {7'd0, so}, 8'd1);
    step(1, 1, 0, 0, 0, 0);
    chk(so === 1'b0, "R3", {7'd0, so}, 8'd0);

    // external test: boundary path only
    load_instr(3'b001);
    chk(mode_extest === 1'b1 && bnd_select === 1'b1, "R8", {7'd0, mode_extest}, 8'd1);
    step(0, 1, 0, 0, 0, 1);
    chk(so === 1'b1, "R8", {7'd0, so}, 8'd1);
    step(0, 1, 0, 0, 1, 0);
    chk(so === 1'b0, "R8", {7'd0, so}, 8'd0);

    // R4 update request without sel_ir is ignored
    for (int i = 0; i < W; i++) step(1, 1, 0, 0, (i == 1), 0);
    step(0, 0, 0, 1, 0, 0);
    chk(mode_extest === 1'b1, "R4", {2'd0, got_modes()}, 8'h12);
    step(1, 0, 0, 1, 0, 0);
    chk(cell_inward === 1'b1 && mode_intest === 1'b1, "R9", {7'd0, cell_inward}, 8'd1);

    load_instr(3'b011);
    chk(cell_inward === 1'b0 && bnd_select === 1'b1, "R9", {7'd0, cell_inward}, 8'd0);

    // unused code decodes as bypass
    load_instr(3'b101);
    chk(mode_bypass === 1'b1 && bnd_select === 1'b0, "R5", {2'd0, got_modes()}, 8'h20);

    // R6 single 1 appears after N-1 further cycles
    step(0, 1, 0, 0, 1, 0);
    for (int i = 1; i < N; i++) begin
      chk(so === 1'b0, "R6", {7'd0, so}, 8'd0);
      step(0, 1, 0, 0, 0, 0);
    end
    chk(so === 1'b1, "R6", {7'd0, so}, 8'd1);

    // R7 capture clears the bypass chain
    for (int i = 0; i < N; i++) step(0, 1, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0, 1);
    chk(so === 1'b0, "R7", {7'd0, so}, 8'd0);

    // R1 asynchronous reset between edges
    load_instr(3'b010);
    wrst_n = 1'b0;
    #0.5;
    chk(got_modes() === 6'b100000, "R1", {2'd0, got_modes()}, 8'h20);
    chk(so === 1'b0, "R1", {7'd0, so}, 8'd0);
    model_reset();
    @(negedge wclk); #1 wrst_n = 1'b1;

    // random operations
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 2) == 0, ($urandom % 10) < 6, ($urandom % 8) == 0,
           ($urandom % 4) == 0, $urandom % 2, $urandom % 2);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule